// File: doc/BRIEF.md
# Data Translation Buffer with Access Checking

This block translates data-side virtual addresses of a 64-bit machine with 8 KB pages into physical addresses. It keeps a small, fully associative set of translations in registers. Each entry holds a 30-bit page tag, an 8-bit address-space number with a global-match bit, a physical page number, and per-mode read and write enable masks with fault-on-read and fault-on-write bits. A request presents a virtual address, a read/write flag, the current mode and address-space number, and a few qualifier flags. One cycle later the block returns a fault class together with a physical address.

The lookup itself is combinational. The outcome is latched by a two-state controller. `S_IDLE` moves to `S_REPORT` when a request arrives, `S_REPORT` stays in `S_REPORT` on a back-to-back request, and it returns to `S_IDLE` when no request follows. A response is visible only in `S_REPORT`.

Faults also load three held registers: the faulting address, a packed status word, and a formatted page-table-entry address. Two other paths bypass the entry array. A kernel-only window of directly mapped addresses is translated without a lookup. Non-canonical addresses are rejected before any lookup. New entries are written round-robin, and entries can be removed by page and address-space number.

Top module: `data_xlate_buffer`

## Requirements
- R1: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. `rsp_fault` uses these codes: 0 none, 1 normal miss, 2 table-walk miss, 3 access violation, 4 translation fault, 5 machine check. `rsp_pa` is 0 for classes 1 to 4.
- R2: On a permitted hit, `rsp_pa` = (PPN << 13) | VA[12:0].
- R3: An entry hits when it is valid, its tag equals VA[42:13], and either its global bit is set or its stored number equals `cur_asn`. The lowest-numbered hitting entry is used.
- R4: Outside PAL mode (`req_pal`=0), when VA[63:43] is neither all zeros nor all ones, the result is class 4 with flags 0x22, plus 0x01 for a write. With `req_pal`=1 this check is skipped.
- R5: When VA[47:41]=0x7e and the effective mode is 0, PA = VA[43:0] with bits 43:40 forced to 0xF if VA[40]=1, and cleared otherwise. In any other mode the result is class 3 with flags 0x02, plus 0x01 for a write.
- R6: A miss gives flags 0x10, plus 0x01 for a write. The class is 2 when `req_vpte`=1 and 1 otherwise.
- R7: A write whose `xwe` bit for the effective mode is 0 gives class 4 with flags 0x03, plus 0x08 if fault-on-write is set. A permitted write with fault-on-write set gives class 4 with flags 0x09.
- R8: A read whose `xre` bit for the effective mode is 0 gives class 3 with flags 0x02, plus 0x04 if fault-on-read is set. Fault-on-read alone does not fault a permitted read.
- R9: For classes 1 to 4, and only when `req_vpte` and `req_nofault` are both 0, the fault registers load. `fault_va` gets VA. `fault_stat` gets opcode in bits 16:11, Ra in bits 10:6 and flags in bits 5:0. `fault_form` gets `form_base` | (VA[42:13] << 3). In every other cycle they hold.
- R10: The effective mode is `cur_mode` when `req_pal`=0. When `req_pal`=1 it is `alt_mode` if `req_alt`=1, and 0 otherwise.
- R11: An insert writes the slot at a pointer, sets it valid, and advances the pointer 0,1,...,N-1,0. The pointer is 0 after reset, so insert N+1 overwrites the first entry.
- R12: A flush invalidates every valid entry whose tag equals `fl_vpn` and whose number equals `fl_asn` or whose global bit is set. Other entries stay valid.
- R13: A permitted hit whose PA has any bit above 43 set gives class 5 and returns that PA. The fault registers are left unchanged.
- R14: After reset no entry is valid, `rsp_valid` is 0, and all fault registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| req_valid | input | 1 | translation request strobe |
| req_va | input | 64 | virtual address |
| req_write | input | 1 | 1 = write access |
| req_pal | input | 1 | PAL mode (PC bit 0) |
| req_alt | input | 1 | use alternate mode in PAL mode |
| req_vpte | input | 1 | request comes from a table walk |
| req_nofault | input | 1 | suppress fault-register update |
| cur_mode | input | 2 | current mode, 0 = kernel |
| alt_mode | input | 2 | alternate mode |
| cur_asn | input | 8 | current address-space number |
| req_opcode | input | 6 | opcode recorded on fault |
| req_ra | input | 5 | Ra field recorded on fault |
| form_base | input | 64 | base for the formatted fault address |
| ins_valid | input | 1 | insert strobe |
| ins_vpn | input | 30 | tag of the new entry |
| ins_asn | input | 8 | address-space number of the new entry |
| ins_asma | input | 1 | global-match bit of the new entry |
| ins_ppn | input | PPN_W | physical page number |
| ins_xre | input | 4 | per-mode read enables |
| ins_xwe | input | 4 | per-mode write enables |
| ins_fonr | input | 1 | fault on read |
| ins_fonw | input | 1 | fault on write |
| fl_valid | input | 1 | flush strobe |
| fl_vpn | input | 30 | page to flush |
| fl_asn | input | 8 | address-space number to flush |
| rsp_valid | output | 1 | response valid |
| rsp_fault | output | 3 | fault class |
| rsp_pa | output | 64 | physical address |
| fault_va | output | 64 | held faulting address |
| fault_stat | output | 17 | held fault status word |
| fault_form | output | 64 | held formatted fault address |

## Verification
Reads and writes go against entries that differ in one property at a time: address-space number against the global bit, kernel-only against all-mode enables, and fault-on bits set against clear. This shows that the match, the mode-indexed mask and the fault-on bits each steer the result on their own.

Addresses just outside the canonical range are sent both in and out of PAL mode. Superpage addresses are sent with VA[40] set and clear, and in several modes. Together these separate the bypass paths from the lookup path.

Table-walk and no-fault requests against fault-register contents known in advance show whether the fault-register update is suppressed. A page number with bit 31 set produces the machine check. Flushes with matching and non-matching numbers, followed by inserts past the table size, show which entries survive.

// File: rtl/dxb_pkg.sv
package dxb_pkg;
    localparam int PG_SH   = 13;
    localparam int VA_IMPL = 43;
    localparam int PA_IMPL = 44;
    localparam int VPN_W   = VA_IMPL - PG_SH;
    localparam int ASN_W   = 8;
    localparam int STAT_W  = 17;

    // flag bit positions inside the status word
    localparam int FB_WR   = 0;
    localparam int FB_ACV  = 1;
    localparam int FB_FONR = 2;
    localparam int FB_FONW = 3;
    localparam int FB_MISS = 4;
    localparam int FB_BAD  = 5;

    typedef enum logic [2:0] {
        FC_NONE     = 3'd0,
        FC_MISS     = 3'd1,
        FC_PTE_MISS = 3'd2,
        FC_ACV      = 3'd3,
        FC_FAULT    = 3'd4,
        FC_MCHK     = 3'd5
    } fclass_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } rsp_state_e;

    typedef struct packed {
        logic [3:0] xre;
        logic [3:0] xwe;
        logic       fonr;
        logic       fonw;
    } perm_t;
endpackage

// File: rtl/dxb_store.sv
module dxb_store
    import dxb_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int PPN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_asma,
    input  perm_t            ins_perm,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic             fl_en,
    input  logic [VPN_W-1:0] fl_vpn,
    input  logic [ASN_W-1:0] fl_asn,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output perm_t            lk_perm,
    output logic [PPN_W-1:0] lk_ppn
);
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    logic [N_ENT-1:0] hit_v;
    perm_t            perm_a [N_ENT];
    logic [PPN_W-1:0] ppn_a  [N_ENT];
    logic [IDX_W-1:0] ptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ins_en) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic             v_q;
        logic [VPN_W-1:0] tag_q;
        logic [ASN_W-1:0] asn_q;
        logic             asma_q;
        perm_t            perm_q;
        logic [PPN_W-1:0] ppn_q;
        logic             wr_sel;
        logic             fl_hit;

        assign wr_sel = ins_en && (ptr_q == IDX_W'(g));
        assign fl_hit = v_q && (tag_q == fl_vpn) && (asma_q || asn_q == fl_asn);
        assign hit_v[g] = v_q && (tag_q == lk_vpn) && (asma_q || asn_q == lk_asn);
        assign perm_a[g] = perm_q;
        assign ppn_a[g]  = ppn_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (wr_sel) begin
                v_q <= 1'b1;
            end else if (fl_en && fl_hit) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_sel) begin
                tag_q  <= ins_vpn;
                asn_q  <= ins_asn;
                asma_q <= ins_asma;
                perm_q <= ins_perm;
                ppn_q  <= ins_ppn;
            end
        end
    end

    // lowest index wins when several entries match
    always_comb begin
        lk_hit  = |hit_v;
        lk_perm = '0;
        lk_ppn  = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                lk_perm = perm_a[i];
                lk_ppn  = ppn_a[i];
            end
        end
    end
endmodule

// File: rtl/dxb_judge.sv
module dxb_judge
    import dxb_pkg::*;
#(
    parameter int PPN_W = 32
) (
    input  logic [63:0]      va,
    input  logic             is_write,
    input  logic             pal,
    input  logic             use_alt,
    input  logic [1:0]       alt_mode,
    input  logic [1:0]       cur_mode,
    input  logic             vpte,
    input  logic             hit,
    input  perm_t            perm,
    input  logic [PPN_W-1:0] ppn,
    output fclass_e          fclass,
    output logic [5:0]       flags,
    output logic [63:0]      pa
);
    localparam int PAD_W = 64 - PG_SH - PPN_W;
    localparam int HI_W  = 64 - VA_IMPL;

    logic [1:0]  eff_mode;
    logic [3:0]  mode_bit;
    logic        canon;
    logic        in_super;
    logic [63:0] tr_pa;
    logic [63:0] sp_pa;

    assign eff_mode = pal ? (use_alt ? alt_mode : 2'd0) : cur_mode;
    assign mode_bit = 4'b0001 << eff_mode;
    assign canon    = (va[63:VA_IMPL] == {HI_W{1'b0}}) || (va[63:VA_IMPL] == {HI_W{1'b1}});
    assign in_super = (va[47:41] == 7'h7e);
    assign tr_pa    = {{PAD_W{1'b0}}, ppn, va[PG_SH-1:0]};

    always_comb begin
        sp_pa = {{(64-PA_IMPL){1'b0}}, va[PA_IMPL-1:0]};
        sp_pa[43:40] = va[40] ? 4'hF : 4'h0;
    end

    always_comb begin
        fclass = FC_NONE;
        flags  = '0;
        pa     = '0;
        if (!pal && !canon) begin
            fclass        = FC_FAULT;
            flags[FB_BAD] = 1'b1;
            flags[FB_ACV] = 1'b1;
            flags[FB_WR]  = is_write;
        end else if (in_super) begin
            if (eff_mode != 2'd0) begin
                fclass        = FC_ACV;
                flags[FB_ACV] = 1'b1;
                flags[FB_WR]  = is_write;
            end else begin
                pa = sp_pa;
            end
        end else if (!hit) begin
            fclass         = vpte ? FC_PTE_MISS : FC_MISS;
            flags[FB_MISS] = 1'b1;
            flags[FB_WR]   = is_write;
        end else if (is_write && (perm.xwe & mode_bit) == 4'b0) begin
            fclass         = FC_FAULT;
            flags[FB_WR]   = 1'b1;
            flags[FB_ACV]  = 1'b1;
            flags[FB_FONW] = perm.fonw;
        end else if (is_write && perm.fonw) begin
            fclass         = FC_FAULT;
            flags[FB_WR]   = 1'b1;
            flags[FB_FONW] = 1'b1;
        end else if (!is_write && (perm.xre & mode_bit) == 4'b0) begin
            fclass         = FC_ACV;
            flags[FB_ACV]  = 1'b1;
            flags[FB_FONR] = perm.fonr;
        end else begin
            pa = tr_pa;
            if (tr_pa[63:PA_IMPL] != '0) begin
                fclass = FC_MCHK;
            end
        end
    end
endmodule

// File: rtl/data_xlate_buffer.sv
module data_xlate_buffer
    import dxb_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int PPN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [63:0]       req_va,
    input  logic              req_write,
    input  logic              req_pal,
    input  logic              req_alt,
    input  logic              req_vpte,
    input  logic              req_nofault,
    input  logic [1:0]        cur_mode,
    input  logic [1:0]        alt_mode,
    input  logic [7:0]        cur_asn,
    input  logic [5:0]        req_opcode,
    input  logic [4:0]        req_ra,
    input  logic [63:0]       form_base,
    input  logic              ins_valid,
    input  logic [29:0]       ins_vpn,
    input  logic [7:0]        ins_asn,
    input  logic              ins_asma,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [3:0]        ins_xre,
    input  logic [3:0]        ins_xwe,
    input  logic              ins_fonr,
    input  logic              ins_fonw,
    input  logic              fl_valid,
    input  logic [29:0]       fl_vpn,
    input  logic [7:0]        fl_asn,
    output logic              rsp_valid,
    output logic [2:0]        rsp_fault,
    output logic [63:0]       rsp_pa,
    output logic [63:0]       fault_va,
    output logic [16:0]       fault_stat,
    output logic [63:0]       fault_form
);
    localparam int FORM_PAD = 64 - VPN_W - 3;

    rsp_state_e       st_q, st_d;
    logic             lk_hit;
    perm_t            lk_perm;
    logic [PPN_W-1:0] lk_ppn;
    fclass_e          fc;
    logic [5:0]       flags;
    logic [63:0]      pa;
    logic             log_fault;
    perm_t            ins_perm;
    fclass_e          fc_q;
    logic [63:0]      pa_q;

    assign ins_perm = '{xre: ins_xre, xwe: ins_xwe, fonr: ins_fonr, fonw: ins_fonw};

    dxb_store #(.N_ENT(N_ENT), .PPN_W(PPN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ins_en   (ins_valid),
        .ins_vpn  (ins_vpn),
        .ins_asn  (ins_asn),
        .ins_asma (ins_asma),
        .ins_perm (ins_perm),
        .ins_ppn  (ins_ppn),
        .fl_en    (fl_valid),
        .fl_vpn   (fl_vpn),
        .fl_asn   (fl_asn),
        .lk_vpn   (req_va[VA_IMPL-1:PG_SH]),
        .lk_asn   (cur_asn),
        .lk_hit   (lk_hit),
        .lk_perm  (lk_perm),
        .lk_ppn   (lk_ppn)
    );

    dxb_judge #(.PPN_W(PPN_W)) u_judge (
        .va       (req_va),
        .is_write (req_write),
        .pal      (req_pal),
        .use_alt  (req_alt),
        .alt_mode (alt_mode),
        .cur_mode (cur_mode),
        .vpte     (req_vpte),
        .hit      (lk_hit),
        .perm     (lk_perm),
        .ppn      (lk_ppn),
        .fclass   (fc),
        .flags    (flags),
        .pa       (pa)
    );

    assign log_fault = (fc != FC_NONE) && (fc != FC_MCHK) && !req_vpte && !req_nofault;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            S_IDLE:   st_d = req_valid ? S_REPORT : S_IDLE;
            S_REPORT: st_d = req_valid ? S_REPORT : S_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_q       <= FC_NONE;
            pa_q       <= '0;
            fault_va   <= '0;
            fault_stat <= '0;
            fault_form <= '0;
        end else if (req_valid) begin
            fc_q <= fc;
            pa_q <= pa;
            if (log_fault) begin
                fault_va   <= req_va;
                fault_stat <= {req_opcode, req_ra, flags};
                fault_form <= form_base | {{FORM_PAD{1'b0}}, req_va[VA_IMPL-1:PG_SH], 3'b000};
            end
        end
    end

    assign rsp_valid = (st_q == S_REPORT);
    assign rsp_fault = fc_q;
    assign rsp_pa    = pa_q;
endmodule

// File: rtl/dxb_sva.sv
module dxb_sva
    import dxb_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic [2:0]  rsp_fault,
    input logic [63:0] rsp_pa,
    input logic [63:0] fault_va,
    input logic [16:0] fault_stat,
    input logic [63:0] fault_form
);
    p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_rsp_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_fault_pa_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FC_NONE && rsp_fault != FC_MCHK) |-> (rsp_pa == 64'd0));

    p_fault_regs_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_valid || rsp_fault == FC_NONE || rsp_fault == FC_MCHK)
        |-> ($stable(fault_va) && $stable(fault_stat) && $stable(fault_form)));

    p_mchk_high_pa_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FC_MCHK) |-> (rsp_pa[63:44] != 20'd0));

    p_ok_pa_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == FC_NONE) |-> (rsp_pa[63:44] == 20'd0));
endmodule

bind data_xlate_buffer dxb_sva u_dxb_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_pa     (rsp_pa),
    .fault_va   (fault_va),
    .fault_stat (fault_stat),
    .fault_form (fault_form)
);

// File: tb/data_xlate_buffer_tb_top.sv
`timescale 1ns/1ps
module data_xlate_buffer_tb_top;
    localparam int NE = 4;
    localparam int PW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          req_valid = 0, req_write = 0, req_pal = 0, req_alt = 0;
    logic          req_vpte = 0, req_nofault = 0;
    logic [63:0]   req_va = '0, form_base = 64'h4_0000_0000;
    logic [1:0]    cur_mode = 0, alt_mode = 0;
    logic [7:0]    cur_asn = 0, ins_asn = 0, fl_asn = 0;
    logic [5:0]    req_opcode = 6'h2c;
    logic [4:0]    req_ra = 5'h0b;
    logic          ins_valid = 0, ins_asma = 0, ins_fonr = 0, ins_fonw = 0, fl_valid = 0;
    logic [29:0]   ins_vpn = '0, fl_vpn = '0;
    logic [PW-1:0] ins_ppn = '0;
    logic [3:0]    ins_xre = '0, ins_xwe = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_fault;
    logic [63:0]   rsp_pa, fault_va, fault_form;
    logic [16:0]   fault_stat;

    data_xlate_buffer #(.N_ENT(NE), .PPN_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_write(req_write), .req_pal(req_pal), .req_alt(req_alt),
        .req_vpte(req_vpte), .req_nofault(req_nofault), .cur_mode(cur_mode),
        .alt_mode(alt_mode), .cur_asn(cur_asn), .req_opcode(req_opcode),
        .req_ra(req_ra), .form_base(form_base), .ins_valid(ins_valid),
        .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_asma(ins_asma),
        .ins_ppn(ins_ppn), .ins_xre(ins_xre), .ins_xwe(ins_xwe),
        .ins_fonr(ins_fonr), .ins_fonw(ins_fonw), .fl_valid(fl_valid),
        .fl_vpn(fl_vpn), .fl_asn(fl_asn), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa), .fault_va(fault_va),
        .fault_stat(fault_stat), .fault_form(fault_form)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit          m_v    [NE];
    logic [29:0] m_tag  [NE];
    logic [7:0]  m_asn  [NE];
    bit          m_asma [NE];
    logic [31:0] m_ppn  [NE];
    logic [3:0]  m_xre  [NE];
    logic [3:0]  m_xwe  [NE];
    bit          m_fonr [NE];
    bit          m_fonw [NE];
    int          m_ptr;
    bit          mdl_on = 0;
    logic        e_rv;
    logic [2:0]  e_fc;
    logic [63:0] e_pa, e_fva, e_ffm;
    logic [16:0] e_fst;

    task automatic model_req();
        int mode, idx;
        logic [63:0] up;
        logic [63:0] p;
        logic [5:0] f;
        int c;
        mode = req_pal ? (req_alt ? int'(alt_mode) : 0) : int'(cur_mode);
        up = req_va >> 43;
        idx = -1;
        for (int i = 0; i < NE; i++)
            if (idx < 0 && m_v[i] && m_tag[i] == req_va[42:13] && (m_asma[i] || m_asn[i] == cur_asn)) idx = i;
        c = 0; f = 0; p = 0;
        if (!req_pal && up != 0 && up != 64'h1F_FFFF) begin
            c = 4; f = 6'h22 | {5'b0, req_write};
        end else if (((req_va >> 41) & 64'h7f) == 64'h7e) begin
            if (mode != 0) begin c = 3; f = 6'h02 | {5'b0, req_write}; end
            else begin
                p = req_va & 64'hFFF_FFFF_FFFF;
                if (p[40]) p = p | 64'hF00_0000_0000; else p = p & 64'hFF_FFFF_FFFF;
            end
        end else if (idx < 0) begin
            c = req_vpte ? 2 : 1; f = 6'h10 | {5'b0, req_write};
        end else if (req_write) begin
            if (m_xwe[idx][mode] == 1'b0) begin c = 4; f = m_fonw[idx] ? 6'h0B : 6'h03; end
            else if (m_fonw[idx]) begin c = 4; f = 6'h09; end
        end else if (m_xre[idx][mode] == 1'b0) begin
            c = 3; f = m_fonr[idx] ? 6'h06 : 6'h02;
        end
        if (c == 0 && !(((req_va >> 41) & 64'h7f) == 64'h7e && (req_pal || up == 0 || up == 64'h1F_FFFF))) begin
            p = (64'(m_ppn[idx]) << 13) | (req_va & 64'h1FFF);
            if ((p >> 44) != 0) c = 5;
        end
        e_fc = 3'(c);
        e_pa = (c == 0 || c == 5) ? p : 64'd0;
        if (c >= 1 && c <= 4 && !req_vpte && !req_nofault) begin
            e_fva = req_va;
            e_fst = {req_opcode, req_ra, f};
            e_ffm = form_base | (64'(req_va[42:13]) << 3);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) m_v[i] = 0;
            m_ptr = 0; e_rv = 0; e_fc = 0; e_pa = 0; e_fva = 0; e_fst = 0; e_ffm = 0;
        end else begin
            e_rv = req_valid;
            if (req_valid) model_req();
            if (fl_valid)
                for (int i = 0; i < NE; i++)
                    if (m_v[i] && m_tag[i] == fl_vpn && (m_asma[i] || m_asn[i] == fl_asn)) m_v[i] = 0;
            if (ins_valid) begin
                m_v[m_ptr] = 1; m_tag[m_ptr] = ins_vpn; m_asn[m_ptr] = ins_asn;
                m_asma[m_ptr] = ins_asma; m_ppn[m_ptr] = ins_ppn; m_xre[m_ptr] = ins_xre;
                m_xwe[m_ptr] = ins_xwe; m_fonr[m_ptr] = ins_fonr; m_fonw[m_ptr] = ins_fonw;
                m_ptr = (m_ptr + 1) % NE;
            end
        end
        mdl_on = 1;
    end

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (mdl_on && !done) begin
            check(cur_tag, "rsp_valid", 64'(rsp_valid), 64'(e_rv));
            if (e_rv) begin
                check(cur_tag, "rsp_fault", 64'(rsp_fault), 64'(e_fc));
                check(cur_tag, "rsp_pa", rsp_pa, e_pa);
            end
            check("R9", "fault_va", fault_va, e_fva);
            check("R9", "fault_stat", 64'(fault_stat), 64'(e_fst));
            check("R9", "fault_form", fault_form, e_ffm);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic insert(input logic [29:0] vpn, input logic [7:0] asn, input logic asma,
                          input logic [31:0] ppn, input logic [3:0] xre, input logic [3:0] xwe,
                          input logic fonr, input logic fonw);
        @(negedge clk);
        ins_valid = 1; ins_vpn = vpn; ins_asn = asn; ins_asma = asma; ins_ppn = ppn;
        ins_xre = xre; ins_xwe = xwe; ins_fonr = fonr; ins_fonw = fonw;
        @(negedge clk);
        ins_valid = 0;
    endtask

    task automatic flush(input logic [29:0] vpn, input logic [7:0] asn);
        @(negedge clk);
        fl_valid = 1; fl_vpn = vpn; fl_asn = asn;
        @(negedge clk);
        fl_valid = 0;
    endtask

    task automatic probe(input string tag, input logic [63:0] va, input logic wr,
                         input logic [1:0] mode, input logic [7:0] asn,
                         input logic [2:0] exp_fc, input logic [5:0] exp_fl, input bit chk_fl,
                         input logic [63:0] exp_pa, input bit chk_pa);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1; req_va = va; req_write = wr; cur_mode = mode; cur_asn = asn;
        @(negedge clk);
        req_valid = 0;
        check(tag, "rsp_valid", 64'(rsp_valid), 64'd1);
        check(tag, "rsp_fault", 64'(rsp_fault), 64'(exp_fc));
        if (chk_fl) check(tag, "fault flags", 64'(fault_stat[5:0]), 64'(exp_fl));
        if (chk_pa) check(tag, "rsp_pa", rsp_pa, exp_pa);
    endtask

    function automatic logic [63:0] va_of(input logic [29:0] vpn, input logic [12:0] off);
        return (64'(vpn) << 13) | 64'(off);
    endfunction

    logic [16:0] saved_st;

    initial begin
        repeat (3) @(negedge clk);
        // R14: reset state
        check("R14", "rsp_valid", 64'(rsp_valid), 64'd0);
        check("R14", "fault_stat", 64'(fault_stat), 64'd0);
        check("R14", "fault_va", fault_va, 64'd0);
        rst_n = 1;
        // R14: nothing valid after reset -> miss
        probe("R14", va_of(30'h12345, 13'h0), 0, 0, 8'd5, 3'd1, 6'h10, 1, 64'd0, 1);

        insert(30'h12345, 8'd5, 0, 32'hABC, 4'b0001, 4'b0011, 0, 0);   // slot 0
        // R2 R3: hit on matching number
        probe("R2", va_of(30'h12345, 13'h1a4), 0, 0, 8'd5, 3'd0, 6'h0, 0, 64'h15781A4, 1);
        // R3 R6 R9: other number misses; status word and formatted address
        probe("R6", va_of(30'h12345, 13'h1a4), 0, 0, 8'd6, 3'd1, 6'h10, 1, 64'd0, 1);
        check("R9", "fault_stat word", 64'(fault_stat), 64'h162D0);
        check("R9", "fault_form", fault_form, 64'h4_0009_1A28);
        check("R9", "fault_va", fault_va, 64'h2468A1A4);
        saved_st = fault_stat;
        // R6 R9: table-walk miss, registers untouched
        req_vpte = 1;
        probe("R6", va_of(30'h12345, 13'h0), 1, 0, 8'd7, 3'd2, 6'h0, 0, 64'd0, 1);
        req_vpte = 0;
        check("R9", "stat held on vpte", 64'(fault_stat), 64'(saved_st));
        // R9: nofault suppresses update
        req_nofault = 1;
        probe("R9", va_of(30'h3, 13'h0), 1, 0, 8'd7, 3'd1, 6'h0, 0, 64'd0, 0);
        req_nofault = 0;
        check("R9", "stat held on nofault", 64'(fault_stat), 64'(saved_st));
        // R8: user read without enable
        probe("R8", va_of(30'h12345, 13'h0), 0, 2, 8'd5, 3'd3, 6'h02, 1, 64'd0, 1);
        // R7: permitted write in mode 1, denied in mode 2
        probe("R7", va_of(30'h12345, 13'h8), 1, 1, 8'd5, 3'd0, 6'h0, 0, 64'h1578008, 1);
        probe("R7", va_of(30'h12345, 13'h8), 1, 2, 8'd5, 3'd4, 6'h03, 1, 64'd0, 1);

        insert(30'h777, 8'd0, 1, 32'h5, 4'hF, 4'hF, 1, 1);   // slot 1, global
        probe("R7", va_of(30'h777, 13'h0), 1, 0, 8'd9, 3'd4, 6'h09, 1, 64'd0, 1);
        probe("R8", va_of(30'h777, 13'h4), 0, 3, 8'd9, 3'd0, 6'h0, 0, 64'hA004, 1);
        insert(30'h888, 8'd1, 0, 32'h6, 4'h0, 4'h0, 1, 1);   // slot 2
        probe("R8", va_of(30'h888, 13'h0), 0, 0, 8'd1, 3'd3, 6'h06, 1, 64'd0, 1);
        probe("R7", va_of(30'h888, 13'h0), 1, 0, 8'd1, 3'd4, 6'h0B, 1, 64'd0, 1);

        // R4: non-canonical
        probe("R4", 64'h0010_0000_0000_0000, 1, 0, 8'd1, 3'd4, 6'h23, 1, 64'd0, 1);
        probe("R4", 64'hFFF0_0000_0000_0000, 0, 0, 8'd1, 3'd4, 6'h22, 1, 64'd0, 1);
        req_pal = 1;
        probe("R4", 64'h0010_0000_0000_0000, 0, 3, 8'd1, 3'd1, 6'h10, 1, 64'd0, 1);
        req_pal = 0;

        // R5: superpage window
        probe("R5", 64'hFFFF_FC00_0000_1234, 0, 0, 8'd0, 3'd0, 6'h0, 0, 64'h1234, 1);
        probe("R5", 64'hFFFF_FD00_0000_1000, 0, 0, 8'd0, 3'd0, 6'h0, 0, 64'hF00_0000_1000, 1);
        probe("R5", 64'hFFFF_FC00_0000_1234, 1, 3, 8'd0, 3'd3, 6'h03, 1, 64'd0, 1);
        // R10: PAL mode without alt runs as kernel; with alt uses alt_mode
        req_pal = 1;
        probe("R10", 64'hFFFF_FC00_0000_0040, 0, 3, 8'd0, 3'd0, 6'h0, 0, 64'h40, 1);
        req_alt = 1; alt_mode = 2;
        probe("R10", 64'hFFFF_FC00_0000_0040, 0, 0, 8'd0, 3'd3, 6'h02, 1, 64'd0, 1);
        alt_mode = 0;
        probe("R10", va_of(30'h12345, 13'h0), 0, 2, 8'd5, 3'd0, 6'h0, 0, 64'h1578000, 1);
        req_alt = 0; req_pal = 0;

        // R13: PA above implemented range
        insert(30'h999, 8'd2, 0, 32'h8000_0001, 4'hF, 4'hF, 0, 0);  // slot 3
        saved_st = fault_stat;
        probe("R13", va_of(30'h999, 13'h10), 0, 1, 8'd2, 3'd5, 6'h0, 0, 64'h1000_0000_2010, 1);
        check("R13", "stat held on mchk", 64'(fault_stat), 64'(saved_st));

        // R12: flush by page and number
        flush(30'h12345, 8'd7);
        probe("R12", va_of(30'h12345, 13'h0), 0, 0, 8'd5, 3'd0, 6'h0, 0, 64'h1578000, 1);
        flush(30'h12345, 8'd5);
        probe("R12", va_of(30'h12345, 13'h0), 0, 0, 8'd5, 3'd1, 6'h10, 1, 64'd0, 1);
        flush(30'h777, 8'd3);
        probe("R12", va_of(30'h777, 13'h0), 1, 0, 8'd9, 3'd1, 6'h11, 1, 64'd0, 1);
        probe("R12", va_of(30'h888, 13'h0), 0, 0, 8'd1, 3'd3, 6'h06, 1, 64'd0, 1);

        // R11: round-robin wrap
        insert(30'hAAA, 8'd0, 1, 32'h10, 4'hF, 4'hF, 0, 0);  // slot 0
        insert(30'hBBB, 8'd0, 1, 32'h11, 4'hF, 4'hF, 0, 0);  // slot 1
        insert(30'hCCC, 8'd0, 1, 32'h12, 4'hF, 4'hF, 0, 0);  // slot 2 evicts 888
        probe("R11", va_of(30'h888, 13'h0), 0, 0, 8'd1, 3'd1, 6'h10, 1, 64'd0, 1);
        probe("R11", va_of(30'h999, 13'h0), 0, 0, 8'd2, 3'd5, 6'h0, 0, 64'h1000_0000_2000, 1);
        probe("R11", va_of(30'hCCC, 13'h1), 0, 0, 8'd0, 3'd0, 6'h0, 0, 64'h24001, 1);
        insert(30'hDDD, 8'd0, 1, 32'h13, 4'hF, 4'hF, 0, 0);  // slot 3 evicts 999
        probe("R11", va_of(30'h999, 13'h0), 0, 0, 8'd2, 3'd1, 6'h10, 1, 64'd0, 1);
        probe("R11", va_of(30'hAAA, 13'h2), 0, 0, 8'd4, 3'd0, 6'h0, 0, 64'h20002, 1);

        // R1: back-to-back requests
        @(negedge clk);
        cur_tag = "R1";
        req_valid = 1; req_va = va_of(30'hBBB, 13'h0); req_write = 0; cur_mode = 0;
        @(negedge clk);
        check("R1", "rsp_valid b2b first", 64'(rsp_valid), 64'd1);
        req_va = va_of(30'h5555, 13'h0);
        @(negedge clk);
        req_valid = 0;
        check("R1", "rsp_valid b2b second", 64'(rsp_valid), 64'd1);
        check("R1", "rsp_fault b2b second", 64'(rsp_fault), 64'd1);
        @(negedge clk);
        check("R1", "rsp_valid drops", 64'(rsp_valid), 64'd0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule